// File: doc/BRIEF.md
# Second-Order Feed-Forward Delta-Sigma Modulator

This block turns a stream of signed fixed-point samples into a single-bit pulse-density stream, one output bit per modulator clock. It is a digital model of a second-order delta-sigma loop. A first accumulator integrates the gap between the sample and a two-level feedback value. A second accumulator integrates the first. A sign decision looks at the second accumulator, twice the first accumulator and the sample itself. Over a long run the fraction of ones tracks the sample, so a later decimation filter can recover a multi-bit word from it.

Samples are 16-bit two's complement. A value of ±25600 is linear full scale, and the feedback levels are ±32768. The stream therefore carries about 89.06 % ones at the positive end and about 10.94 % at the negative end. A sample at the top or bottom code of the word is treated as 128 % overrange. It pins the output to a constant level, and the accumulators freeze so that they do not wind up. Both accumulators also clamp at a fixed symmetric bound instead of wrapping. A clock enable stalls the whole loop.

Top module: `dsm_mod2_ff`

## Requirements
- R1: While `rst` is high at a clock edge, `bit_out` is 0 after that edge and both accumulators are cleared. With `din` = 0 and `en` high from the release of reset, the bits that follow the first eight edges are 1,0,0,1,1,0,0,1.
- R2: With `din` = 0, the count of ones over 4096 consecutive enabled clocks is 2048 within ±12.
- R3: For any `din` in the linear range −25600..+25600, the count of ones over 4096 enabled clocks is 4096·(din+32768)/65536 within ±12. At ±25600 this gives 3648 and 448, which are 89.06 % and 10.94 %.
- R4: When `din` = +32767 (the top code, +128 % of full scale) with `en` high, `bit_out` is 1 after the next clock edge and stays 1 for as long as the input remains there.
- R5: When `din` ≤ −32767 (−128 % of full scale or below) with `en` high, `bit_out` is 0 after the next clock edge and stays 0 for as long as the input remains there.
- R6: While `en` is low, `bit_out` and both accumulators hold, and `din` has no effect. Once `en` returns high, the bit sequence continues exactly where it stopped.
- R7: The accumulators saturate at ±(2^(ACC_W−1)−1) and do not integrate during an overrange input. A linear input applied after any overrange stretch therefore gives the density of R3 again after 64 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable for the loop; low stalls state and output |
| din | input | 16 | Signed input sample, ±25600 = linear full scale |
| bit_out | output | 1 | Registered one-bit modulator output |

## Verification
The clocked assertions assume that `rst` is high at the first rising edge. They also assume that `din` and `en` change only away from the rising edge, so each edge sees one stable sample. The overrange and hold properties compare a decision made at one edge with the output after the next edge, which holds only if the input was settled when the edge came. The bench meets these assumptions by holding reset for several cycles and by driving every input 1 ns after a rising edge. It samples the output at that same point. It also lets the loop settle for 64 clocks before counting ones, so a density window never mixes two input levels.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    // Classification of the input sample against the overrange thresholds
    typedef enum logic [1:0] {
        RANGE_LINEAR  = 2'd0,
        RANGE_OVER_HI = 2'd1,
        RANGE_OVER_LO = 2'd2
    } range_e;

endpackage

// File: rtl/dsm_integrator.sv
module dsm_integrator #(
    parameter int ACC_W = 24,
    parameter int ADD_W = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    hold,
    input  logic signed [ADD_W-1:0] addend,
    output logic signed [ACC_W-1:0] acc
);

    localparam int SUM_W = ACC_W + 1;
    localparam logic signed [SUM_W-1:0] POS_LIM = {2'b00, {(ACC_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] NEG_LIM = {2'b11, {(ACC_W-2){1'b0}}, 1'b1};

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
    } integ_t;

    integ_t st_d, st_q;
    logic signed [SUM_W-1:0] sum_d;

    always_comb begin
        st_d  = st_q;
        sum_d = SUM_W'(st_q.acc) + SUM_W'(addend);
        if (en && !hold) begin
            if (sum_d > POS_LIM) begin
                st_d.acc = POS_LIM[ACC_W-1:0];
            end else if (sum_d < NEG_LIM) begin
                st_d.acc = NEG_LIM[ACC_W-1:0];
            end else begin
                st_d.acc = sum_d[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.acc;

    // Pinned at the upper bound, a non-negative addend must not move it
    assert_sat_high_R7: assert property (@(posedge clk) disable iff (rst)
        (en && !hold && acc == POS_LIM[ACC_W-1:0] && !addend[ADD_W-1])
        |=> (acc == POS_LIM[ACC_W-1:0]));

    // Pinned at the lower bound, a non-positive addend must not move it
    assert_sat_low_R7: assert property (@(posedge clk) disable iff (rst)
        (en && !hold && acc == NEG_LIM[ACC_W-1:0] && (addend[ADD_W-1] || addend == '0))
        |=> (acc == NEG_LIM[ACC_W-1:0]));

    // Stalled or frozen accumulators keep their value
    assert_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (!en || hold) |=> $stable(acc));

endmodule

// File: rtl/dsm_quantizer.sv
module dsm_quantizer
    import dsm_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int ACC_W = 24
) (
    input  logic signed [IN_W-1:0]  x,
    input  logic signed [ACC_W-1:0] stage1,
    input  logic signed [ACC_W-1:0] stage2,
    output range_e                  range_o,
    output logic                    decide_o
);

    localparam int V_W = ACC_W + 3;
    localparam logic signed [IN_W-1:0] OVER_HI = {1'b0, {(IN_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] OVER_LO = {1'b1, {(IN_W-2){1'b0}}, 1'b1};

    logic signed [V_W-1:0] v_sum;

    always_comb begin
        // Feed-forward sum: second stage, weighted first stage, and the sample
        v_sum = V_W'(stage2) + (V_W'(stage1) <<< 1) + V_W'(x);

        if (x >= OVER_HI) begin
            range_o = RANGE_OVER_HI;
        end else if (x <= OVER_LO) begin
            range_o = RANGE_OVER_LO;
        end else begin
            range_o = RANGE_LINEAR;
        end

        unique case (range_o)
            RANGE_OVER_HI: decide_o = 1'b1;
            RANGE_OVER_LO: decide_o = 1'b0;
            default:       decide_o = ~v_sum[V_W-1];
        endcase
    end

endmodule

// File: rtl/dsm_mod2_ff.sv
module dsm_mod2_ff
    import dsm_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int ACC_W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic signed [IN_W-1:0] din,
    output logic                   bit_out
);

    localparam int ERR_W = IN_W + 2;
    localparam logic signed [ERR_W-1:0] FB_POS = {3'b001, {(IN_W-1){1'b0}}};
    localparam logic signed [ERR_W-1:0] FB_NEG = {3'b111, {(IN_W-1){1'b0}}};
    localparam logic signed [IN_W-1:0]  TOP_CODE = {1'b0, {(IN_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0]  LOW_EDGE = {1'b1, {(IN_W-2){1'b0}}, 1'b1};

    typedef struct packed {
        logic bit_o;
    } out_t;

    out_t                     st_d, st_q;
    logic signed [ACC_W-1:0]  stage1_q, stage2_q;
    logic signed [ERR_W-1:0]  err_d;
    logic                     decide;
    logic                     freeze;
    range_e                   rng;

    dsm_quantizer #(
        .IN_W  (IN_W),
        .ACC_W (ACC_W)
    ) u_quant (
        .x        (din),
        .stage1   (stage1_q),
        .stage2   (stage2_q),
        .range_o  (rng),
        .decide_o (decide)
    );

    always_comb begin
        freeze = (rng != RANGE_LINEAR);
        err_d  = ERR_W'(din) - (decide ? FB_POS : FB_NEG);
        st_d   = st_q;
        if (en) begin
            st_d.bit_o = decide;
        end
    end

    dsm_integrator #(
        .ACC_W (ACC_W),
        .ADD_W (ERR_W)
    ) u_stage1 (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .hold   (freeze),
        .addend (err_d),
        .acc    (stage1_q)
    );

    dsm_integrator #(
        .ACC_W (ACC_W),
        .ADD_W (ACC_W)
    ) u_stage2 (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .hold   (freeze),
        .addend (stage1_q),
        .acc    (stage2_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_out = st_q.bit_o;

    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !bit_out);

    assert_over_high_R4: assert property (@(posedge clk) disable iff (rst)
        (en && din == TOP_CODE) |=> bit_out);

    assert_over_low_R5: assert property (@(posedge clk) disable iff (rst)
        (en && din <= LOW_EDGE) |=> !bit_out);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(bit_out));

endmodule

// File: tb/dsm_mod2_ff_tb.sv
module dsm_mod2_ff_tb;

    localparam int WIN   = 4096;
    localparam int TOL   = 12;
    localparam int VEC_N = 7;
    localparam int VEC_DIN  [VEC_N] = '{0, 25600, -25600, 12800, -16384, 8192, -4096};
    localparam int VEC_ONES [VEC_N] = '{2048, 3648, 448, 2848, 1024, 2560, 1792};

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en  = 1'b1;
    logic signed [15:0] din = '0;
    logic               bit_out;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    dsm_mod2_ff u_dut (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .din     (din),
        .bit_out (bit_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic count_ones(input int n, output int ones);
        ones = 0;
        for (int k = 0; k < n; k++) begin
            tick();
            if (bit_out) ones++;
        end
    endtask

    task automatic density(input int value, input int exp, input string req);
        int ones;
        int diff;
        din = 16'(value);
        repeat (64) tick();
        count_ones(WIN, ones);
        diff = ones - exp;
        if (diff < 0) diff = -diff;
        check(diff <= TOL, req, ones, exp);
    endtask

    initial begin
        int ones;
        bit exp_seq [8] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

        // R1: reset state and the zero-input start pattern
        repeat (3) tick();
        check(bit_out == 1'b0, "R1 reset output", int'(bit_out), 0);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) begin
            tick();
            check(bit_out == exp_seq[k], "R1 start pattern", int'(bit_out), int'(exp_seq[k]));
        end

        // R6: stall in mid-pattern, wild input ignored, then resume
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        check(bit_out == 1'b1, "R6 pre-stall bit 0", int'(bit_out), 1);
        tick();
        check(bit_out == 1'b0, "R6 pre-stall bit 1", int'(bit_out), 0);
        en  = 1'b0;
        din = 16'sd20000;
        count_ones(10, ones);
        check(ones == 0, "R6 output held while stalled", ones, 0);
        en  = 1'b1;
        din = '0;
        tick();
        check(bit_out == 1'b0, "R6 resume bit 2", int'(bit_out), 0);
        tick();
        check(bit_out == 1'b1, "R6 resume bit 3", int'(bit_out), 1);

        // R2 and R3: ones density across the linear range
        for (int v = 0; v < VEC_N; v++) begin
            density(VEC_DIN[v], VEC_ONES[v], (v == 0) ? "R2 zero input density" : "R3 linear density");
        end

        // R4: top code pins the output high from the next edge
        din = 16'sh7FFF;
        tick();
        check(bit_out == 1'b1, "R4 first edge", int'(bit_out), 1);
        count_ones(300, ones);
        check(ones == 300, "R4 steady ones", ones, 300);

        // R5: bottom boundary and most negative code pin the output low
        din = -16'sd32767;
        tick();
        check(bit_out == 1'b0, "R5 boundary first edge", int'(bit_out), 0);
        din = 16'sh8000;
        count_ones(300, ones);
        check(ones == 0, "R5 steady zeros", ones, 0);

        // R7: back to linear operation after a long overrange stretch
        din = 16'sh7FFF;
        repeat (2000) tick();
        density(0, 2048, "R7 recovery density");
        density(-25600, 448, "R7 recovery at negative full scale");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule